// File: doc/BRIEF.md
# Stereo Serial Audio Output Port

This block sends left and right converter samples, 18 bits wide, out of a chip as a serial stream. The stream has a bit clock, a left/right clock, a data line and a word clock. A sample pair is offered with a one-cycle valid strobe. The port takes the most recent pair at the start of each left field and shifts it out MSB first, in two's complement, one bit per bit-clock period.

Three static select pins choose the operating mode:
- Master or slave timing. In master mode the port makes its own bit clock and left/right clock from the system clock. In slave mode it follows clocks supplied from outside.
- A 64-bit frame with two 32-bit fields, or a 32-bit frame with two 16-bit fields.
- The word clock behaviour: driven, sampled, held high or unused.

In the 64-bit frame an alignment select places the sample within its field in one of three ways: right-justified, I2S, or starting at a programmable bit offset. The 32-bit frame keeps the 16 most significant sample bits and fills each field with them.

Top module: `stereo_serial_out`

## Requirements
- R1: The select code {frame_sel, s1_sel, s0_sel} sets the mode as follows:
  - 100: 64-bit master, word clock driven out.
  - 101: 64-bit master, word clock sampled in.
  - 111: 64-bit slave.
  - 000: 32-bit master, word clock held high.
  - 001: 32-bit master, word clock unused.
  - 011: 32-bit slave.
  - 110 and 010: reserved.

  `clk_drive` is 1 exactly in the four master codes.
- R2: In master mode `bck_out` runs at the system clock divided by 4, high for 2 cycles and low for 2 cycles.
- R3: In master mode `lrck_out` is 1 during the left field and 0 during the right field. Each field lasts 32 bit clocks in the 64-bit frame and 16 in the 32-bit frame. The left field comes first in a frame.
- R4: Data is sent MSB first and changes only on a falling bit-clock edge, so it is stable while `bck_out` is high. `sdata_out`, `bck_out` and `lrck_out` are 0 while reset is held.
- R5: With `align_mode` 0 or 3 in the 64-bit frame, the 18-bit sample is right-justified. Its MSB is in slot 14 of the field and its LSB in slot 31; slots 0 to 13 are 0. Slot 0 is the first bit after the left/right clock changes.
- R6: With `align_mode` 1 in the 64-bit frame, the MSB is in slot 1, one bit clock after the left/right clock changes. Slot 0 and slots 19 to 31 are 0.
- R7: With `align_mode` 2 in the 64-bit frame, the MSB is in slot `msb_offset`. Sample bits that would fall past slot 31 are dropped, and the other slots are 0.
- R8: In the 32-bit frame, bits 17 down to 2 of the sample fill slots 0 to 15 of each field, whatever `align_mode` is.
- R9: A pair strobed in with `in_valid` is first sent in the frame that starts after the strobe. A strobe during a frame does not change the frame already being sent.
- R10: In code 100, `wck_out` is 1 in slots 0 to 15 of each field and 0 in slots 16 to 31. In code 000, `wck_out` is held at 1. `wck_drive` is 1 in those two codes only; in every other code `wck_out` is 0.
- R11: In code 101, a slot carries its data bit only if `wck_in` was high when that slot began; otherwise the slot is 0.
- R12: In the slave codes, `bck_out` and `lrck_out` stay 0. Data is clocked by the falling edges of `bck_in`. A change of `lrck_in` restarts the field, and a change to 1 loads a new pair. Data changes on the second system clock edge after a `bck_in` fall.
- R13: In a reserved code, `sdata_out`, `bck_out` and `clk_drive` stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (master clock) |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_sel | input | 1 | Frame size select: 1 for 64-bit, 0 for 32-bit |
| s1_sel | input | 1 | Mode select bit 1 |
| s0_sel | input | 1 | Mode select bit 0 |
| align_mode | input | 2 | Alignment in the 64-bit frame: 0/3 right-justified, 1 I2S, 2 offset |
| msb_offset | input | 5 | MSB slot used when `align_mode` is 2 |
| in_valid | input | 1 | Strobe that captures a sample pair |
| left_in | input | 18 | Left sample, two's complement |
| right_in | input | 18 | Right sample, two's complement |
| bck_in | input | 1 | External bit clock (slave modes) |
| lrck_in | input | 1 | External left/right clock (slave modes) |
| wck_in | input | 1 | External word clock (code 101) |
| bck_out | output | 1 | Generated bit clock |
| lrck_out | output | 1 | Generated left/right clock |
| clk_drive | output | 1 | High when the port drives the bit and left/right clocks |
| wck_out | output | 1 | Generated word clock |
| wck_drive | output | 1 | High when the port drives the word clock |
| sdata_out | output | 1 | Serial data |

## Verification
In master mode every slot is four system clocks long. Data, the left/right clock and the word clock all move at the falling edge of the bit clock. The checks therefore sample at the first falling system-clock edge that sees `bck_out` high, which is two cycles after the slot began. They also watch that the data does not move while `bck_out` stays high.

In slave mode the data is due two system clock edges after the bench drops `bck_in`. The bench holds each half of its bit clock for four system clocks and samples just before it raises `bck_in` again.

A new pair is due at the next left-field start. The checks therefore compare whole captured frames, and they start capturing only once a rising left/right clock has been seen.

// File: rtl/ssp_pkg.sv
package ssp_pkg;

  typedef struct packed {
    logic master;
    logic slave;
    logic reserved;
    logic frame64;
    logic wck_out;
    logic wck_in;
    logic wck_high;
  } ssp_mode_t;

  typedef enum logic [1:0] {
    ALIGN_RIGHT     = 2'd0,
    ALIGN_I2S       = 2'd1,
    ALIGN_USER      = 2'd2,
    ALIGN_RIGHT_ALT = 2'd3
  } ssp_align_e;

endpackage

// File: rtl/ssp_mode_decode.sv
module ssp_mode_decode
  import ssp_pkg::*;
(
  input  logic      frame_sel,
  input  logic      s1_sel,
  input  logic      s0_sel,
  output ssp_mode_t mode
);

  always_comb begin
    mode = '0;
    mode.frame64 = frame_sel;
    unique case ({s1_sel, s0_sel})
      2'b00: begin
        mode.master   = 1'b1;
        mode.wck_out  = frame_sel;
        mode.wck_high = ~frame_sel;
      end
      2'b01: begin
        mode.master = 1'b1;
        mode.wck_in = frame_sel;
      end
      2'b11:   mode.slave    = 1'b1;
      default: mode.reserved = 1'b1;
    endcase
  end

endmodule

// File: rtl/ssp_master_timing.sv
module ssp_master_timing #(
  parameter int BCK_DIV    = 4,
  parameter int FRAME_BITS = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic frame64,
  output logic tick,
  output logic lr_next,
  output logic bck
);

  localparam int DIV_W  = $clog2(BCK_DIV);
  localparam int CNT_W  = $clog2(FRAME_BITS);
  localparam int HALF_F = FRAME_BITS / 2;

  logic [DIV_W-1:0] div_q, div_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_nxt, cnt_mask;

  always_comb begin
    tick     = en && (div_q == DIV_W'(BCK_DIV - 1));
    cnt_mask = frame64 ? {CNT_W{1'b1}} : CNT_W'(HALF_F - 1);
    cnt_nxt  = (cnt_q + CNT_W'(1)) & cnt_mask;
    lr_next  = frame64 ? ~cnt_nxt[CNT_W-1] : ~cnt_nxt[CNT_W-2];
    bck      = (div_q >= DIV_W'(BCK_DIV / 2));
    div_d    = div_q;
    cnt_d    = cnt_q;
    if (en) div_d = tick ? '0 : div_q + DIV_W'(1);
    if (tick) cnt_d = cnt_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      cnt_q <= '1;
    end else begin
      div_q <= div_d;
      cnt_q <= cnt_d;
    end
  end

  assert_bck_low_after_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !bck) else $error("bit clock not low after slot tick");

  assert_bck_fall_on_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bck) |-> $past(tick)) else $error("bit clock fell without slot tick");

endmodule

// File: rtl/ssp_slave_timing.sv
module ssp_slave_timing (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic bck_in,
  input  logic lrck_in,
  input  logic wck_in,
  output logic tick,
  output logic lr_next,
  output logic wck_sync
);

  logic bck_s0, bck_s1, lr_s0, wck_s0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bck_s0 <= 1'b0;
      bck_s1 <= 1'b0;
      lr_s0  <= 1'b0;
      wck_s0 <= 1'b0;
    end else begin
      bck_s0 <= bck_in;
      bck_s1 <= bck_s0;
      lr_s0  <= lrck_in;
      wck_s0 <= wck_in;
    end
  end

  always_comb begin
    tick     = en & bck_s1 & ~bck_s0;
    lr_next  = lr_s0;
    wck_sync = wck_s0;
  end

endmodule

// File: rtl/ssp_field_seq.sv
module ssp_field_seq
  import ssp_pkg::*;
#(
  parameter int SAMPLE_W    = 18,
  parameter int SHORT_W     = 16,
  parameter int FIELD_LONG  = 32,
  parameter int FIELD_SHORT = 16,
  parameter int POS_W       = 6,
  parameter int OFF_W       = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                frame64,
  input  logic                reserved,
  input  logic                wck_gate_en,
  input  logic [1:0]          align_mode,
  input  logic [OFF_W-1:0]    msb_offset,
  input  logic                in_valid,
  input  logic [SAMPLE_W-1:0] left_in,
  input  logic [SAMPLE_W-1:0] right_in,
  input  logic                tick,
  input  logic                lr_next,
  input  logic                wck_sync,
  output logic                side,
  output logic [POS_W-1:0]    pos,
  output logic                sdata
);

  localparam logic [POS_W-1:0] POS_MAX = '1;

  logic [SAMPLE_W-1:0] hold_l_q, hold_l_d, hold_r_q, hold_r_d;
  logic [SAMPLE_W-1:0] word_l_q, word_l_d, word_r_q, word_r_d;
  logic                side_q, side_d, gate_q, gate_d;
  logic [POS_W-1:0]    pos_q, pos_d;

  logic [POS_W-1:0]    msb_pos, k, wlen, flen;
  logic [SAMPLE_W-1:0] word_sel, shifted;
  logic                in_win;

  // next state
  always_comb begin
    hold_l_d = hold_l_q;
    hold_r_d = hold_r_q;
    word_l_d = word_l_q;
    word_r_d = word_r_q;
    side_d   = side_q;
    pos_d    = pos_q;
    gate_d   = gate_q;
    if (in_valid) begin
      hold_l_d = left_in;
      hold_r_d = right_in;
    end
    if (tick) begin
      gate_d = wck_sync;
      if (lr_next != side_q) begin
        side_d = lr_next;
        pos_d  = '0;
        if (lr_next) begin
          word_l_d = hold_l_q;
          word_r_d = hold_r_q;
        end
      end else if (pos_q != POS_MAX) begin
        pos_d = pos_q + POS_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_l_q <= '0;
      hold_r_q <= '0;
      word_l_q <= '0;
      word_r_q <= '0;
      side_q   <= 1'b0;
      pos_q    <= '0;
      gate_q   <= 1'b0;
    end else begin
      hold_l_q <= hold_l_d;
      hold_r_q <= hold_r_d;
      word_l_q <= word_l_d;
      word_r_q <= word_r_d;
      side_q   <= side_d;
      pos_q    <= pos_d;
      gate_q   <= gate_d;
    end
  end

  // bit selection for the current slot
  always_comb begin
    unique case (ssp_align_e'(align_mode))
      ALIGN_I2S:  msb_pos = POS_W'(1);
      ALIGN_USER: msb_pos = POS_W'(msb_offset);
      default:    msb_pos = POS_W'(FIELD_LONG - SAMPLE_W);
    endcase
    if (!frame64) msb_pos = '0;
    wlen     = frame64 ? POS_W'(SAMPLE_W) : POS_W'(SHORT_W);
    flen     = frame64 ? POS_W'(FIELD_LONG) : POS_W'(FIELD_SHORT);
    k        = pos_q - msb_pos;
    in_win   = (pos_q >= msb_pos) && (k < wlen) && (pos_q < flen);
    word_sel = side_q ? word_l_q : word_r_q;
    shifted  = word_sel << k;
    sdata    = in_win & shifted[SAMPLE_W-1] & ~reserved & (~wck_gate_en | gate_q);
    side     = side_q;
    pos      = pos_q;
  end

  assert_left_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tick && lr_next && !side_q |=> side_q && (pos_q == '0))
    else $error("left field did not restart at slot 0");

  assert_hold_between_ticks_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(pos_q) && $stable(side_q) && $stable(word_l_q) && $stable(word_r_q))
    else $error("slot state moved without a tick");

  assert_slot_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tick && (lr_next == side_q) && (pos_q != POS_MAX) |=> pos_q == $past(pos_q) + POS_W'(1))
    else $error("slot index did not advance by one");

endmodule

// File: rtl/stereo_serial_out.sv
module stereo_serial_out
  import ssp_pkg::*;
#(
  parameter int SAMPLE_W   = 18,
  parameter int SHORT_W    = 16,
  parameter int FIELD_LONG = 32,
  parameter int BCK_DIV    = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          frame_sel,
  input  logic                          s1_sel,
  input  logic                          s0_sel,
  input  logic [1:0]                    align_mode,
  input  logic [$clog2(FIELD_LONG)-1:0] msb_offset,
  input  logic                          in_valid,
  input  logic [SAMPLE_W-1:0]           left_in,
  input  logic [SAMPLE_W-1:0]           right_in,
  input  logic                          bck_in,
  input  logic                          lrck_in,
  input  logic                          wck_in,
  output logic                          bck_out,
  output logic                          lrck_out,
  output logic                          clk_drive,
  output logic                          wck_out,
  output logic                          wck_drive,
  output logic                          sdata_out
);

  localparam int FRAME_BITS  = 2 * FIELD_LONG;
  localparam int FIELD_SHORT = SHORT_W;
  localparam int POS_W       = $clog2(FIELD_LONG) + 1;
  localparam int OFF_W       = $clog2(FIELD_LONG);

  logic rst_meta, rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_n_s  <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_n_s  <= rst_meta;
    end
  end

  ssp_mode_t mode;
  logic m_tick, m_lr, m_bck, s_tick, s_lr, wck_sync;
  logic tick, lr_next, side;
  logic [POS_W-1:0] pos;

  ssp_mode_decode u_decode (
    .frame_sel (frame_sel),
    .s1_sel    (s1_sel),
    .s0_sel    (s0_sel),
    .mode      (mode)
  );

  ssp_master_timing #(
    .BCK_DIV    (BCK_DIV),
    .FRAME_BITS (FRAME_BITS)
  ) u_master (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .en      (mode.master),
    .frame64 (mode.frame64),
    .tick    (m_tick),
    .lr_next (m_lr),
    .bck     (m_bck)
  );

  ssp_slave_timing u_slave (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .en       (mode.slave),
    .bck_in   (bck_in),
    .lrck_in  (lrck_in),
    .wck_in   (wck_in),
    .tick     (s_tick),
    .lr_next  (s_lr),
    .wck_sync (wck_sync)
  );

  always_comb begin
    tick    = m_tick | s_tick;
    lr_next = mode.master ? m_lr : s_lr;
  end

  ssp_field_seq #(
    .SAMPLE_W    (SAMPLE_W),
    .SHORT_W     (SHORT_W),
    .FIELD_LONG  (FIELD_LONG),
    .FIELD_SHORT (FIELD_SHORT),
    .POS_W       (POS_W),
    .OFF_W       (OFF_W)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n_s),
    .frame64     (mode.frame64),
    .reserved    (mode.reserved),
    .wck_gate_en (mode.wck_in),
    .align_mode  (align_mode),
    .msb_offset  (msb_offset),
    .in_valid    (in_valid),
    .left_in     (left_in),
    .right_in    (right_in),
    .tick        (tick),
    .lr_next     (lr_next),
    .wck_sync    (wck_sync),
    .side        (side),
    .pos         (pos),
    .sdata       (sdata_out)
  );

  always_comb begin
    clk_drive = mode.master;
    bck_out   = mode.master & m_bck;
    lrck_out  = mode.master & side;
    wck_drive = mode.wck_out | mode.wck_high;
    wck_out   = mode.wck_high | (mode.wck_out & (pos < POS_W'(FIELD_LONG / 2)));
  end

endmodule

// File: tb/stereo_serial_out_test.sv
`timescale 1ns/1ps
module stereo_serial_out_test;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_sel = 1'b1, s1_sel = 1'b0, s0_sel = 1'b0;
  logic [1:0] align_mode = 2'd0;
  logic [4:0] msb_offset = 5'd0;
  logic in_valid = 1'b0;
  logic [17:0] left_in = '0, right_in = '0;
  logic bck_in = 1'b1, lrck_in = 1'b0, wck_in = 1'b1;
  logic bck_out, lrck_out, clk_drive, wck_out, wck_drive, sdata_out;

  int checks = 0;
  int errors = 0;
  int stable_bad = 0;

  always #2 clk = ~clk;

  stereo_serial_out uut (
    .clk(clk), .rst_n(rst_n), .frame_sel(frame_sel), .s1_sel(s1_sel), .s0_sel(s0_sel),
    .align_mode(align_mode), .msb_offset(msb_offset), .in_valid(in_valid),
    .left_in(left_in), .right_in(right_in), .bck_in(bck_in), .lrck_in(lrck_in),
    .wck_in(wck_in), .bck_out(bck_out), .lrck_out(lrck_out), .clk_drive(clk_drive),
    .wck_out(wck_out), .wck_drive(wck_drive), .sdata_out(sdata_out)
  );

  localparam logic [17:0] A_L = 18'h2D5A3, A_R = 18'h0F0F1;
  localparam logic [17:0] B_L = 18'h1ACE5, B_R = 18'h25B39;
  localparam logic [17:0] C_L = 18'h33C0F, C_R = 18'h0A5A5;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] exp_long(input logic [1:0] al, input logic [4:0] off,
                                           input logic [17:0] l, input logic [17:0] r);
    logic [63:0] v = '0;
    for (int f = 0; f < 2; f++) begin
      for (int p = 0; p < 32; p++) begin
        int msb;
        int k;
        logic [17:0] w;
        msb = (al == 2'd1) ? 1 : (al == 2'd2) ? int'(off) : 14;
        k = p - msb;
        w = (f == 0) ? l : r;
        if (k >= 0 && k < 18) v[63-(f*32+p)] = w[17-k];
      end
    end
    return v;
  endfunction

  function automatic logic [63:0] exp_short(input logic [17:0] l, input logic [17:0] r);
    logic [63:0] v = '0;
    for (int f = 0; f < 2; f++) begin
      for (int p = 0; p < 16; p++) begin
        v[63-(f*16+p)] = (f == 0) ? l[17-p] : r[17-p];
      end
    end
    return v;
  endfunction

  task automatic set_mode(input logic f, input logic a, input logic b,
                          input logic [1:0] al, input logic [4:0] off);
    rst_n = 1'b0;
    frame_sel = f; s1_sel = a; s0_sel = b;
    align_mode = al; msb_offset = off;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic load_pair(input logic [17:0] l, input logic [17:0] r);
    @(negedge clk);
    in_valid = 1'b1; left_in = l; right_in = r;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // Capture nbits slots from the next left-field start, sampling at bit-clock rise.
  task automatic capture(input int nbits, input int inj_at, input logic [17:0] il,
                         input logic [17:0] ir, output logic [63:0] d,
                         output logic [63:0] lr, output logic [63:0] wk);
    int n = 0;
    bit started = 0;
    logic plr = 1'b1;
    logic pb, pd;
    d = '0; lr = '0; wk = '0;
    pb = bck_out; pd = sdata_out;
    while (n < nbits) begin
      @(negedge clk);
      if (in_valid) in_valid = 1'b0;
      if (bck_out && !pb) begin
        if (!started) begin
          if (lrck_out && !plr) started = 1;
          plr = lrck_out;
        end
        if (started) begin
          d[63-n] = sdata_out; lr[63-n] = lrck_out; wk[63-n] = wck_out;
          if (n == inj_at) begin
            in_valid = 1'b1; left_in = il; right_in = ir;
          end
          n++;
        end
      end else if (bck_out && pb && sdata_out != pd) begin
        stable_bad++;
      end
      pb = bck_out; pd = sdata_out;
    end
  endtask

  task automatic measure_bck(input string req);
    logic pb;
    int per = 0, hi = 0;
    pb = bck_out;
    forever begin
      @(negedge clk);
      if (bck_out && !pb) break;
      pb = bck_out;
    end
    pb = 1'b1;
    forever begin
      @(negedge clk);
      per++;
      if (bck_out) hi++;
      if (bck_out && !pb) break;
      pb = bck_out;
    end
    chk(per == 4, req, "bit clock period", per, 4);
    chk(hi == 2, req, "bit clock high cycles", hi, 2);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(!sdata_out && !bck_out && !lrck_out, "R4", "outputs during reset",
        {sdata_out, bck_out, lrck_out}, 0);
  endtask

  task automatic t_master_right;
    logic [63:0] d, lr, wk;
    set_mode(1'b1, 1'b0, 1'b0, 2'd0, 5'd0);
    load_pair(A_L, A_R);
    stable_bad = 0;
    capture(64, -1, '0, '0, d, lr, wk);
    capture(64, -1, '0, '0, d, lr, wk);
    chk(d == exp_long(2'd0, 5'd0, A_L, A_R), "R5", "right-justified frame", d,
        exp_long(2'd0, 5'd0, A_L, A_R));
    chk(lr == 64'hFFFFFFFF00000000, "R3", "lrck in 64-bit frame", lr, 64'hFFFFFFFF00000000);
    chk(wk == 64'hFFFF0000FFFF0000, "R10", "word clock out pattern", wk, 64'hFFFF0000FFFF0000);
    chk(wck_drive == 1'b1, "R10", "word clock drive in code 100", wck_drive, 1);
    chk(clk_drive == 1'b1, "R1", "master drives clocks", clk_drive, 1);
    chk(stable_bad == 0, "R4", "data moved while bit clock high", stable_bad, 0);
    measure_bck("R2");
  endtask

  task automatic t_align_variants;
    logic [63:0] d, lr, wk;
    set_mode(1'b1, 1'b0, 1'b0, 2'd3, 5'd0);
    load_pair(B_L, B_R);
    capture(64, -1, '0, '0, d, lr, wk);
    capture(64, -1, '0, '0, d, lr, wk);
    chk(d == exp_long(2'd0, 5'd0, B_L, B_R), "R5", "align code 3 right-justified", d,
        exp_long(2'd0, 5'd0, B_L, B_R));
    set_mode(1'b1, 1'b0, 1'b0, 2'd1, 5'd0);
    load_pair(B_L, B_R);
    capture(64, -1, '0, '0, d, lr, wk);
    capture(64, -1, '0, '0, d, lr, wk);
    chk(d == exp_long(2'd1, 5'd0, B_L, B_R), "R6", "I2S frame", d,
        exp_long(2'd1, 5'd0, B_L, B_R));
    set_mode(1'b1, 1'b0, 1'b0, 2'd2, 5'd20);
    load_pair(A_L, A_R);
    capture(64, -1, '0, '0, d, lr, wk);
    capture(64, -1, '0, '0, d, lr, wk);
    chk(d == exp_long(2'd2, 5'd20, A_L, A_R), "R7", "offset 20 with discard", d,
        exp_long(2'd2, 5'd20, A_L, A_R));
    set_mode(1'b1, 1'b0, 1'b0, 2'd2, 5'd3);
    load_pair(C_L, C_R);
    capture(64, -1, '0, '0, d, lr, wk);
    capture(64, -1, '0, '0, d, lr, wk);
    chk(d == exp_long(2'd2, 5'd3, C_L, C_R), "R7", "offset 3 frame", d,
        exp_long(2'd2, 5'd3, C_L, C_R));
  endtask

  task automatic t_load_timing;
    logic [63:0] d, lr, wk;
    set_mode(1'b1, 1'b0, 1'b0, 2'd0, 5'd0);
    load_pair(A_L, A_R);
    capture(64, -1, '0, '0, d, lr, wk);
    capture(64, 40, C_L, C_R, d, lr, wk);
    chk(d == exp_long(2'd0, 5'd0, A_L, A_R), "R9", "frame kept during mid-frame strobe", d,
        exp_long(2'd0, 5'd0, A_L, A_R));
    capture(64, -1, '0, '0, d, lr, wk);
    chk(d == exp_long(2'd0, 5'd0, C_L, C_R), "R9", "new pair in following frame", d,
        exp_long(2'd0, 5'd0, C_L, C_R));
  endtask

  task automatic t_short_frame;
    logic [63:0] d, lr, wk;
    set_mode(1'b0, 1'b0, 1'b0, 2'd1, 5'd7);
    load_pair(A_L, B_R);
    capture(32, -1, '0, '0, d, lr, wk);
    capture(32, -1, '0, '0, d, lr, wk);
    chk(d[63:32] == exp_short(A_L, B_R)[63:32], "R8", "32-bit truncated frame",
        d[63:32], exp_short(A_L, B_R)[63:32]);
    chk(lr[63:32] == 32'hFFFF0000, "R3", "lrck in 32-bit frame", lr[63:32], 32'hFFFF0000);
    chk(wck_out && wck_drive, "R10", "word clock held high in code 000",
        {wck_out, wck_drive}, 2'b11);
    measure_bck("R2");
    set_mode(1'b0, 1'b0, 1'b1, 2'd0, 5'd0);
    load_pair(C_L, C_R);
    capture(32, -1, '0, '0, d, lr, wk);
    capture(32, -1, '0, '0, d, lr, wk);
    chk(d[63:32] == exp_short(C_L, C_R)[63:32], "R1", "code 001 is 32-bit master",
        d[63:32], exp_short(C_L, C_R)[63:32]);
    chk(!wck_out && !wck_drive, "R10", "word clock unused in code 001",
        {wck_out, wck_drive}, 0);
  endtask

  task automatic t_wck_gate;
    logic [63:0] d, lr, wk;
    wck_in = 1'b0;
    set_mode(1'b1, 1'b0, 1'b1, 2'd0, 5'd0);
    load_pair(A_L, A_R);
    capture(64, -1, '0, '0, d, lr, wk);
    capture(64, -1, '0, '0, d, lr, wk);
    chk(d == 64'd0, "R11", "data gated by low word clock", d, 0);
    chk(!wck_drive, "R10", "word clock not driven in code 101", wck_drive, 0);
    wck_in = 1'b1;
    capture(64, -1, '0, '0, d, lr, wk);
    capture(64, -1, '0, '0, d, lr, wk);
    chk(d == exp_long(2'd0, 5'd0, A_L, A_R), "R11", "data passes with high word clock", d,
        exp_long(2'd0, 5'd0, A_L, A_R));
  endtask

  task automatic t_reserved;
    int bad = 0;
    set_mode(1'b1, 1'b1, 1'b0, 2'd0, 5'd0);
    load_pair(B_L, B_R);
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (sdata_out || bck_out || clk_drive) bad++;
    end
    set_mode(1'b0, 1'b1, 1'b0, 2'd0, 5'd0);
    load_pair(B_L, B_R);
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (sdata_out || bck_out || clk_drive) bad++;
    end
    chk(bad == 0, "R13", "reserved codes stay quiet", bad, 0);
  endtask

  task automatic slave_frames(input int fbits, output logic [63:0] d, output int clk_bad);
    d = '0;
    clk_bad = 0;
    for (int fr = 0; fr < 2; fr++) begin
      for (int s = 0; s < 2 * fbits; s++) begin
        @(negedge clk);
        bck_in = 1'b0;
        lrck_in = (s < fbits);
        repeat (4) @(negedge clk);
        if (fr == 1) d[63-s] = sdata_out;
        if (bck_out || lrck_out || clk_drive) clk_bad++;
        bck_in = 1'b1;
        repeat (3) @(negedge clk);
      end
    end
  endtask

  task automatic t_slave;
    logic [63:0] d;
    int cb;
    bck_in = 1'b1; lrck_in = 1'b0;
    set_mode(1'b1, 1'b1, 1'b1, 2'd0, 5'd0);
    load_pair(C_L, A_R);
    slave_frames(32, d, cb);
    chk(d == exp_long(2'd0, 5'd0, C_L, A_R), "R12", "64-bit slave frame", d,
        exp_long(2'd0, 5'd0, C_L, A_R));
    chk(cb == 0, "R12", "no clock drive in slave", cb, 0);
    bck_in = 1'b1; lrck_in = 1'b0;
    set_mode(1'b0, 1'b1, 1'b1, 2'd0, 5'd0);
    load_pair(B_L, C_R);
    slave_frames(16, d, cb);
    chk(d[63:32] == exp_short(B_L, C_R)[63:32], "R12", "32-bit slave frame", d[63:32],
        exp_short(B_L, C_R)[63:32]);
    chk(cb == 0, "R1", "code 011 is slave", cb, 0);
  endtask

  initial begin
    #(4 * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_master_right();
    t_align_variants();
    t_load_timing();
    t_short_frame();
    t_wck_gate();
    t_reserved();
    t_slave();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule